// File: doc/BRIEF.md
# Serial Interrupt Line Agent

This block is the peripheral end of a shared, single-wire serialized interrupt line. Each local interrupt request line has its own assigned frame number. The agent watches the shared line and recognises the Start Frame that opens a cycle. It then counts three-clock frames to find its slots. In each assigned frame it pulls the line low when that request is active. The host ends each cycle with a Stop Frame, and the agent measures the width of that pulse to learn whether the next cycle runs in Quiet or in Continuous mode.

In Quiet mode the agent may open a cycle itself when a request has changed since it was last reported. It pulls the line low for one clock and then lets go, so the host can finish the Start Frame. In Continuous mode only the host opens cycles. The line is modelled as an open-drain wire. The agent presents an enable and a value, and outside logic combines them with the other drivers and the pull-up.

Top module: `sirq_agent`

## Requirements
- R1: While reset is held and after it is released, the agent does not drive the line (`sirq_oe` = 0) and reports Continuous mode (`quiet_mode` = 0).
- R2: When idle, the agent treats a low sample as the start of a Start Frame. The first rising edge that then samples the line high is slot clock 0. Frame f covers slot clocks 3f (sample), 3f+1 (recovery) and 3f+2 (turnaround). The output for slot clock j takes effect from that edge.
- R3: In the sample clock of frame f, the agent drives low (`sirq_oe` = 1, `sirq_out` = 0) when some request line whose slot number equals f is high. Lines that share a slot are combined by OR. With no such line high, it does not drive.
- R4: In the recovery clock that follows its own low drive, the agent drives high for exactly one clock. In every turnaround clock it releases the line.
- R5: After the last frame, a low pulse of exactly 2 clocks sets Quiet mode and a pulse of exactly 3 clocks sets Continuous mode. `quiet_mode` changes at the edge that first samples the line high again.
- R6: In Quiet mode, with a pending change, the agent's own start drive begins at the second edge after the edge that saw the Stop Frame end, and no earlier. It lasts exactly one clock, and then the line is released.
- R7: In Continuous mode the agent never begins a Start Frame, even with a pending change.
- R8: A stop pulse of any other width (1, or 4 and more clocks) returns the agent to idle in Continuous mode.
- R9: A change is pending when a request line differs from the value it had in its last sample clock. After reset all recorded values are 0. Without a pending change the agent does not start a cycle.
- R10: During the frames the agent ignores low samples on the line and keeps counting to the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sirq_in | input | 1 | Sampled level of the shared line |
| irq_req | input | N_IRQ | Local interrupt request lines, active high |
| irq_slot | input | N_IRQ*FRAME_W | Frame number of each request line, line i in bits [i*FRAME_W +: FRAME_W] |
| sirq_oe | output | 1 | Drive enable for the shared line |
| sirq_out | output | 1 | Level driven when enabled |
| quiet_mode | output | 1 | 1 when the next cycle is in Quiet mode |

## Verification
The assertions assume that the sampled line follows the wired-low rule: it reads low whenever the agent drives low. They also assume that the request vector and the slot numbers change only between clock edges. The bench builds the line from the agent's drive, a host drive and a pull-up, and it changes requests only on the falling edge. The host places its Stop Frame at least one clock after the last turnaround. A deliberate low glitch inside the frames checks that the agent does not react to it.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_START  = 2'd1,
    SQ_FRAMES = 2'd2,
    SQ_STOPW  = 2'd3
  } sirq_seq_e;

  localparam logic [1:0] PH_SAMPLE  = 2'd0;
  localparam logic [1:0] PH_RECOVER = 2'd1;
  localparam logic [1:0] PH_TURN    = 2'd2;

  localparam int STOP_CNT_W = 3;

endpackage

// File: rtl/sirq_slot_match.sv
module sirq_slot_match #(
  parameter int N_IRQ   = 4,
  parameter int FRAME_W = 5
) (
  input  logic [N_IRQ*FRAME_W-1:0] slot_vec_i,
  input  logic [FRAME_W-1:0]       frame_i,
  output logic [N_IRQ-1:0]         hit_o
);

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_cmp
    assign hit_o[gi] = (slot_vec_i[gi*FRAME_W +: FRAME_W] == frame_i);
  end

endmodule

// File: rtl/sirq_report_track.sv
module sirq_report_track #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] capture_i,
  input  logic [N_IRQ-1:0] req_i,
  output logic             pending_o
);

  logic [N_IRQ-1:0] rep_q;
  logic [N_IRQ-1:0] rep_d;

  always_comb begin
    rep_d = (rep_q & ~capture_i) | (req_i & capture_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
    end else begin
      rep_q <= rep_d;
    end
  end

  assign pending_o = |(rep_q ^ req_i);

  // R9: a captured line is no longer a difference in the following cycle
  // when the request holds its level
  p_capture_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((capture_i == {N_IRQ{1'b1}}) && $stable(req_i)) |=> (rep_q == $past(req_i)));

endmodule

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 17,
  parameter int FRAME_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_i,
  output logic [FRAME_W-1:0] frame_nxt_o,
  output logic [1:0]         phase_nxt_o,
  output logic               frames_nxt_o,
  output logic               frames_q_o,
  output logic [1:0]         phase_q_o,
  output logic               start_ok_o,
  output logic               quiet_o
);

  localparam logic [FRAME_W-1:0]    LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);
  localparam logic [STOP_CNT_W-1:0] W_MAX      = {STOP_CNT_W{1'b1}};
  localparam logic [STOP_CNT_W-1:0] W_QUIET    = STOP_CNT_W'(2);
  localparam logic [STOP_CNT_W-1:0] W_CONT     = STOP_CNT_W'(3);

  sirq_seq_e              state_q, state_d;
  logic [FRAME_W-1:0]     frame_q, frame_d;
  logic [1:0]             phase_q, phase_d;
  logic [STOP_CNT_W-1:0]  width_q, width_d;
  logic                   quiet_q, quiet_d;
  logic                   hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    phase_d = phase_q;
    width_d = width_q;
    quiet_d = quiet_q;
    hold_d  = hold_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (!line_i) begin
          state_d = SQ_START;
        end else if (hold_q) begin
          hold_d = 1'b0;
        end
      end
      SQ_START: begin
        if (line_i) begin
          state_d = SQ_FRAMES;
          frame_d = '0;
          phase_d = PH_SAMPLE;
        end
      end
      SQ_FRAMES: begin
        if (phase_q == PH_TURN) begin
          phase_d = PH_SAMPLE;
          if (frame_q == LAST_FRAME) begin
            state_d = SQ_STOPW;
            width_d = '0;
          end else begin
            frame_d = frame_q + 1'b1;
          end
        end else begin
          phase_d = phase_q + 2'd1;
        end
      end
      SQ_STOPW: begin
        if (!line_i) begin
          if (width_q != W_MAX) begin
            width_d = width_q + 1'b1;
          end
        end else if (width_q != '0) begin
          state_d = SQ_IDLE;
          quiet_d = (width_q == W_QUIET);
          hold_d  = (width_q == W_QUIET);
          width_d = '0;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      frame_q <= '0;
      phase_q <= PH_SAMPLE;
      width_q <= '0;
      quiet_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      phase_q <= phase_d;
      width_q <= width_d;
      quiet_q <= quiet_d;
      hold_q  <= hold_d;
    end
  end

  assign frame_nxt_o  = frame_d;
  assign phase_nxt_o  = phase_d;
  assign frames_nxt_o = (state_d == SQ_FRAMES);
  assign frames_q_o   = (state_q == SQ_FRAMES);
  assign phase_q_o    = phase_q;
  assign start_ok_o   = (state_q == SQ_IDLE) && line_i && quiet_q && !hold_q;
  assign quiet_o      = quiet_q;

  // R5: two-clock stop selects Quiet, three-clock stop selects Continuous
  p_stop_two_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STOPW && line_i && width_q == W_QUIET) |=> (quiet_q && state_q == SQ_IDLE));
  p_stop_three_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STOPW && line_i && width_q == W_CONT) |=> (!quiet_q && state_q == SQ_IDLE));
  // R8: any other width falls back to idle in Continuous mode
  p_bad_width_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STOPW && line_i && width_q != '0 && width_q != W_QUIET && width_q != W_CONT)
    |=> (!quiet_q && state_q == SQ_IDLE));
  // R10: low samples inside the frames do not leave the frame sequence early
  p_frames_ignore_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_FRAMES && !line_i && !(frame_q == LAST_FRAME && phase_q == PH_TURN))
    |=> (state_q == SQ_FRAMES));

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int N_IRQ      = 4,
  parameter int NUM_FRAMES = 17,
  localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sirq_in,
  input  logic [N_IRQ-1:0]         irq_req,
  input  logic [N_IRQ*FRAME_W-1:0] irq_slot,
  output logic                     sirq_oe,
  output logic                     sirq_out,
  output logic                     quiet_mode
);

  logic [FRAME_W-1:0] frame_nxt;
  logic [1:0]         phase_nxt;
  logic [1:0]         phase_q;
  logic               frames_nxt;
  logic               frames_q;
  logic               start_ok;
  logic               pending;
  logic [N_IRQ-1:0]   slot_hit;
  logic [N_IRQ-1:0]   capture;
  logic               sample_nxt;
  logic               drive_slot;
  logic               drive_recov;
  logic               drive_start;

  logic oe_q, oe_d;
  logic out_q, out_d;
  logic start_q, start_d;

  sirq_frame_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .FRAME_W    (FRAME_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (sirq_in),
    .frame_nxt_o  (frame_nxt),
    .phase_nxt_o  (phase_nxt),
    .frames_nxt_o (frames_nxt),
    .frames_q_o   (frames_q),
    .phase_q_o    (phase_q),
    .start_ok_o   (start_ok),
    .quiet_o      (quiet_mode)
  );

  sirq_slot_match #(
    .N_IRQ   (N_IRQ),
    .FRAME_W (FRAME_W)
  ) u_match (
    .slot_vec_i (irq_slot),
    .frame_i    (frame_nxt),
    .hit_o      (slot_hit)
  );

  sirq_report_track #(
    .N_IRQ (N_IRQ)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .req_i     (irq_req),
    .pending_o (pending)
  );

  always_comb begin
    sample_nxt  = frames_nxt && (phase_nxt == PH_SAMPLE);
    capture     = sample_nxt ? slot_hit : '0;
    drive_slot  = sample_nxt && |(slot_hit & irq_req);
    drive_recov = frames_nxt && (phase_nxt == PH_RECOVER) && oe_q && !out_q;
    drive_start = start_ok && pending;
    oe_d        = drive_slot || drive_recov || drive_start;
    out_d       = drive_recov;
    start_d     = drive_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      oe_q    <= oe_d;
      out_q   <= out_d;
      start_q <= start_d;
    end
  end

  assign sirq_oe  = oe_q;
  assign sirq_out = out_q;

  // R4: own low in a sample clock is followed by exactly one high clock
  p_recover_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frames_q && phase_q == PH_SAMPLE && oe_q && !out_q) |=> (oe_q && out_q));
  // R4: turnaround clocks are released
  p_turn_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frames_q && phase_q == PH_TURN) |-> !oe_q);
  // R6: the agent's own start drive lasts one clock
  p_start_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !oe_q);
  // R7: a start drive only ever appears in Quiet mode
  p_start_quiet_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> quiet_mode);
  // R3: driving high only happens in recovery
  p_high_only_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && out_q) |-> (frames_q && phase_q == PH_RECOVER));

endmodule

// File: tb/sirq_agent_tb_top.sv
module sirq_agent_tb_top;

  localparam int NI = 4;
  localparam int NF = 17;
  localparam int FW = $clog2(NF);

  logic clk;
  logic rst_n;
  logic host_low;
  logic [NI-1:0] irq_req;
  logic [NI*FW-1:0] irq_slot;
  logic sirq_oe, sirq_out, quiet_mode;
  wire line = !(host_low || (sirq_oe && !sirq_out));

  int n_checks = 0;
  int n_errors = 0;
  bit timed_out = 0;

  sirq_agent #(.N_IRQ(NI), .NUM_FRAMES(NF)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sirq_in    (line),
    .irq_req    (irq_req),
    .irq_slot   (irq_slot),
    .sirq_oe    (sirq_oe),
    .sirq_out   (sirq_out),
    .quiet_mode (quiet_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int slot_of [NI];
  initial begin
    slot_of[0] = 1; slot_of[1] = 5; slot_of[2] = 5; slot_of[3] = 16;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_j, m_w, m_hold;
  bit m_quiet, m_oe, m_out;
  bit [NI-1:0] m_rep;
  bit model_on = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_j = 0; m_w = 0; m_hold = 0;
      m_quiet = 0; m_oe = 0; m_out = 0; m_rep = '0;
    end else begin
      bit lv;
      bit do_slot;
      lv = line;
      do_slot = 0;
      case (m_st)
        0: begin
          if (!lv) begin m_st = 1; m_oe = 0; end
          else if (m_hold > 0) begin m_hold--; m_oe = 0; end
          else if (m_quiet && (irq_req != m_rep)) begin m_oe = 1; m_out = 0; end
          else m_oe = 0;
        end
        1: begin
          if (lv) begin m_st = 2; m_j = 0; do_slot = 1; end
          else m_oe = 0;
        end
        2: begin
          m_j++;
          if (m_j == 3*NF) begin m_st = 3; m_w = 0; m_oe = 0; end
          else do_slot = 1;
        end
        default: begin
          if (!lv) begin if (m_w < 7) m_w++; m_oe = 0; end
          else if (m_w > 0) begin
            m_quiet = (m_w == 2);
            m_hold  = (m_w == 2) ? 1 : 0;
            m_st = 0; m_w = 0; m_oe = 0;
          end
        end
      endcase
      if (do_slot) begin
        case (m_j % 3)
          0: begin
            bit d;
            d = 0;
            for (int i = 0; i < NI; i++) begin
              if (slot_of[i] == m_j / 3) begin
                if (irq_req[i]) d = 1;
                m_rep[i] = irq_req[i];
              end
            end
            m_oe = d; m_out = 0;
          end
          1: begin m_oe = m_oe && !m_out; m_out = 1; end
          default: m_oe = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(sirq_oe == m_oe, "R3 model drive enable", sirq_oe, m_oe);
      if (sirq_oe && m_oe) chk(sirq_out == m_out, "R4 model drive level", sirq_out, m_out);
      chk(quiet_mode == m_quiet, "R5 model mode", quiet_mode, m_quiet);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_pulse(input int n);
    host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
  endtask

  // start pulse (optional), frames with directed checks, then stop pulse
  task automatic run_cycle(input int start_len, input int stop_w, input int glitch_j,
                           input logic [NI-1:0] req_after);
    int bad_after_glitch;
    bad_after_glitch = 0;
    if (start_len > 0) host_pulse(start_len);
    for (int j = 0; j < 3*NF + 2; j++) begin
      @(negedge clk);
      host_low = (j == glitch_j);
      if (j < 3*NF) begin
        bit any_req;
        int f, p;
        f = j / 3; p = j % 3;
        any_req = 0;
        for (int i = 0; i < NI; i++)
          if (slot_of[i] == f && irq_req[i]) any_req = 1;
        if (p == 0 && any_req) begin
          chk(sirq_oe && !sirq_out, "R2 R3 sample low", {sirq_oe, sirq_out}, 2);
          if (j > glitch_j && glitch_j >= 0 && !(sirq_oe && !sirq_out)) bad_after_glitch++;
        end else if (p == 1 && any_req) begin
          chk(sirq_oe && sirq_out, "R4 recovery high", {sirq_oe, sirq_out}, 3);
        end else if (p == 2) begin
          chk(!sirq_oe, "R4 turnaround release", sirq_oe, 0);
        end else begin
          chk(!sirq_oe, "R3 no drive", sirq_oe, 0);
        end
      end
    end
    host_low = 1'b0;
    if (glitch_j >= 0) chk(bad_after_glitch == 0, "R10 frames after glitch", bad_after_glitch, 0);
    irq_req = req_after;
    host_pulse(stop_w);
  endtask

  task automatic expect_silent(input int n, input string tag);
    int drove;
    drove = 0;
    repeat (n) begin
      @(negedge clk);
      if (sirq_oe) drove++;
    end
    chk(drove == 0, tag, drove, 0);
  endtask

  task automatic main_seq();
    host_low = 1'b0;
    irq_req  = '0;
    for (int i = 0; i < NI; i++) irq_slot[i*FW +: FW] = FW'(slot_of[i]);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sirq_oe, "R1 released in reset", sirq_oe, 0);
    chk(!quiet_mode, "R1 continuous in reset", quiet_mode, 0);
    rst_n = 1'b1;
    model_on = 1;
    repeat (3) @(negedge clk);
    chk(!sirq_oe && !quiet_mode, "R1 after reset", {sirq_oe, quiet_mode}, 0);

    // continuous cycle, lines 0 and 2 active
    irq_req = 4'b0101;
    run_cycle(4, 3, -1, 4'b0101);
    @(negedge clk);
    chk(!quiet_mode, "R5 three-clock stop continuous", quiet_mode, 0);
    repeat (3) @(negedge clk);

    // all lines active, glitch inside frames, two-clock stop, nothing pending
    irq_req = 4'b1111;
    run_cycle(4, 2, 7, 4'b1111);
    @(negedge clk);
    chk(quiet_mode, "R5 two-clock stop quiet", quiet_mode, 1);
    expect_silent(20, "R9 no pending no start");

    // quiet, change applied during stop pulse -> agent start timing
    run_cycle(4, 2, -1, 4'b1110);
    @(negedge clk);
    chk(!sirq_oe, "R6 no drive at stop end edge", sirq_oe, 0);
    @(negedge clk);
    chk(!sirq_oe, "R6 no drive one clock later", sirq_oe, 0);
    @(negedge clk);
    chk(sirq_oe && !sirq_out, "R6 start drive at second clock", {sirq_oe, sirq_out}, 2);
    @(negedge clk);
    chk(!sirq_oe, "R6 start drive released", sirq_oe, 0);
    host_pulse(2);

    // continuous with pending change
    run_cycle(0, 3, -1, 4'b1001);
    @(negedge clk);
    chk(!quiet_mode, "R7 continuous mode", quiet_mode, 0);
    expect_silent(20, "R7 no start in continuous");

    // one-clock stop -> error
    run_cycle(4, 1, -1, 4'b0110);
    @(negedge clk);
    chk(!quiet_mode, "R8 width one continuous", quiet_mode, 0);
    expect_silent(20, "R8 idle after width one");

    // quiet again, then five-clock stop -> error
    run_cycle(4, 2, -1, 4'b0110);
    @(negedge clk);
    chk(quiet_mode, "R5 quiet before bad stop", quiet_mode, 1);
    repeat (3) @(negedge clk);
    run_cycle(4, 5, -1, 4'b0110);
    @(negedge clk);
    chk(!quiet_mode, "R8 width five continuous", quiet_mode, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    model_on = 0;
    if (timed_out) chk(0, "R1 watchdog expired", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule